// File: doc/BRIEF.md
# Funnel Shifter with Rotate

This block is a purely combinational 32-bit shifter. Every supported operation becomes the same action: form a wide funnel word from an upper word and a lower word, move it right by some amount, and keep the lowest 32 bits. A small decode stage fills the two words and picks the effective amount from a 2-bit operation code. The four operations are logical right, arithmetic right, logical left and rotate right.

The right-moving network is a chain of 2:1 multiplexer levels that move by 1, 2, 4, 8 and 16 positions. Each level is controlled by one bit of the amount. A logical left shift by k needs a right move of 32 - k. The decode stage supplies the funnel word already moved one position, and the network moves it by the bitwise inverse of k, so the 5-bit network also covers k = 0. The shifter is meant to sit inside an execution unit. Its result is valid in the same cycle as its inputs.

Top module: `funnel_shifter`

## Requirements
- R1: With op_i = 2'b00 (logical right), result_o equals data_i moved right by amount_i, and zeros fill the vacated upper bits.
- R2: With op_i = 2'b01 (arithmetic right), result_o equals data_i moved right by amount_i, and copies of data_i[31] fill the vacated upper bits.
- R3: With op_i = 2'b10 (logical left), result_o equals data_i moved left by amount_i, and the lowest amount_i bits are zero.
- R4: With op_i = 2'b11 (rotate right), result_o equals data_i rotated right by amount_i, so bits leaving at bit 0 re-enter at bit 31.
- R5: An amount_i of 0 returns data_i unchanged for every operation code.
- R6: At the largest amount, 31, a logical right shift leaves only data_i[31] in bit 0, a logical left shift leaves only data_i[0] in bit 31, and an arithmetic right shift yields all copies of data_i[31].
- R7: The block has no state. result_o follows any change of data_i, amount_i or op_i without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_i | input | 32 | Operand to shift or rotate |
| amount_i | input | 5 | Shift or rotate count, 0 to 31 |
| op_i | input | 2 | 00 logical right, 01 arithmetic right, 10 logical left, 11 rotate right |
| result_o | output | 32 | Shifted or rotated operand |

## Verification
The embedded assertions check several properties whenever the inputs change. These are: zero fill at the top for logical right moves, a kept sign bit for arithmetic moves, zeros in the low bits after a left move, an unchanged count of ones after a rotate, and identity at a zero amount. Only the bench's scenarios can show that every bit lands in exactly the right position. The bench sweeps every amount for each operation code over random and patterned operands, with directed cases at amounts 0 and 31. It also changes the inputs between clock edges, which shows that the output does not wait for a clock.

// File: rtl/funnel_pkg.sv
package funnel_pkg;
  typedef enum logic [1:0] {
    OP_SRL = 2'b00,
    OP_SRA = 2'b01,
    OP_SLL = 2'b10,
    OP_ROR = 2'b11
  } shift_op_e;
endpackage

// File: rtl/funnel_front.sv
module funnel_front import funnel_pkg::*; #(
  parameter int W     = 32,
  parameter int AMT_W = $clog2(W),
  localparam int FW   = W + (1 << AMT_W) - 1
) (
  input  logic [W-1:0]     data_i,
  input  logic [AMT_W-1:0] amount_i,
  input  logic [1:0]       op_i,
  output logic [FW-1:0]    funnel_o,
  output logic [AMT_W-1:0] amt_o
);
  // Top bit of the {hi,lo} pair is never reachable in 0..31, so it is dropped.
  always_comb begin
    unique case (shift_op_e'(op_i))
      OP_SRL: begin
        funnel_o = {{(W-1){1'b0}}, data_i};
        amt_o    = amount_i;
      end
      OP_SRA: begin
        funnel_o = {{(W-1){data_i[W-1]}}, data_i};
        amt_o    = amount_i;
      end
      OP_SLL: begin
        // {data,0} pre-moved by 1, then moved by ~k: total 32-k.
        funnel_o = {data_i, {(W-1){1'b0}}};
        amt_o    = ~amount_i;
      end
      default: begin
        funnel_o = {data_i[W-2:0], data_i};
        amt_o    = amount_i;
      end
    endcase
  end

  always_comb begin
    if (op_i == OP_ROR)
      assert_ror_feedback_R4: assert (funnel_o[FW-1:W] == data_i[W-2:0]);
    if (op_i == OP_SLL)
      assert_sll_amount_inverted_R3: assert ((amt_o + amount_i) == {AMT_W{1'b1}});
  end
endmodule

// File: rtl/funnel_level.sv
module funnel_level #(
  parameter int IN_W  = 63,
  parameter int SHIFT = 1,
  localparam int OUT_W = IN_W - SHIFT
) (
  input  logic [IN_W-1:0]  d_i,
  input  logic             sel_i,
  output logic [OUT_W-1:0] q_o
);
  assign q_o = sel_i ? d_i[IN_W-1:SHIFT] : d_i[OUT_W-1:0];
endmodule

// File: rtl/funnel_shifter.sv
module funnel_shifter import funnel_pkg::*; #(
  parameter int W      = 32,
  localparam int AMT_W = $clog2(W),
  localparam int FW    = W + (1 << AMT_W) - 1
) (
  input  logic [W-1:0]     data_i,
  input  logic [AMT_W-1:0] amount_i,
  input  logic [1:0]       op_i,
  output logic [W-1:0]     result_o
);
  logic [FW-1:0]    funnel;
  logic [AMT_W-1:0] amt;

  funnel_front #(.W(W), .AMT_W(AMT_W)) i_front (
    .data_i   (data_i),
    .amount_i (amount_i),
    .op_i     (op_i),
    .funnel_o (funnel),
    .amt_o    (amt)
  );

  // Level i moves by 2**i; each level drops bits no later level can reach.
  for (genvar i = 0; i < AMT_W; i++) begin : g_lvl
    localparam int IN_W  = FW - ((1 << i) - 1);
    localparam int OUT_W = IN_W - (1 << i);
    logic [OUT_W-1:0] q;
    if (i == 0) begin : g_first
      funnel_level #(.IN_W(IN_W), .SHIFT(1 << i)) i_level (
        .d_i(funnel), .sel_i(amt[i]), .q_o(q)
      );
    end else begin : g_next
      funnel_level #(.IN_W(IN_W), .SHIFT(1 << i)) i_level (
        .d_i(g_lvl[i-1].q), .sel_i(amt[i]), .q_o(q)
      );
    end
  end

  assign result_o = g_lvl[AMT_W-1].q;

  logic [W-1:0] low_mask;
  assign low_mask = (W'(1) << amount_i) - W'(1);

  always_comb begin
    if (op_i == OP_SRL && amount_i != '0)
      assert_srl_zero_fill_R1: assert (result_o[W-1] == 1'b0);
    if (op_i == OP_SRA)
      assert_sra_sign_kept_R2: assert (result_o[W-1] == data_i[W-1]);
    if (op_i == OP_SLL)
      assert_sll_low_zero_R3: assert ((result_o & low_mask) == '0);
    if (op_i == OP_ROR)
      assert_ror_ones_kept_R4: assert ($countones(result_o) == $countones(data_i));
    if (amount_i == '0)
      assert_zero_amount_identity_R5: assert (result_o == data_i);
  end
endmodule

// File: tb/test_funnel_shifter.sv
module test_funnel_shifter;
  logic        clk = 1'b0;
  logic [31:0] data;
  logic [4:0]  amount;
  logic [1:0]  op;
  logic [31:0] result;
  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  funnel_shifter i_funnel_shifter (
    .data_i(data), .amount_i(amount), .op_i(op), .result_o(result)
  );

  function automatic logic [31:0] expect_val(logic [1:0] o, logic [31:0] d, int k);
    case (o)
      2'b00:   return d >> k;
      2'b01:   return $unsigned($signed(d) >>> k);
      2'b10:   return d << k;
      default: return (k == 0) ? d : ((d >> k) | (d << (32 - k)));
    endcase
  endfunction

  function automatic string req_of(logic [1:0] o);
    case (o)
      2'b00:   return "R1";
      2'b01:   return "R2";
      2'b10:   return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s op=%b amt=%0d data=%h actual=%h expected=%h",
               req, op, amount, data, act, exp);
    end
  endtask

  task automatic apply(string req, logic [1:0] o, logic [31:0] d, int k);
    @(negedge clk);
    op = o; data = d; amount = 5'(k);
    #1;
    check(req, result, expect_val(o, d, k));
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] pats [6];
    void'($urandom(32'h1f2e3d4c));
    op = 2'b00; data = '0; amount = '0;
    #1;
    check("R1", result, 32'h0);  // idle inputs give zero

    pats[0] = 32'hFFFF_FFFF; pats[1] = 32'h8000_0000; pats[2] = 32'h0000_0001;
    pats[3] = 32'h7FFF_FFFF; pats[4] = 32'hA5A5_5A5A; pats[5] = 32'h8000_0001;

    // exhaustive amounts per op, patterned and random operands
    for (int o = 0; o < 4; o++)
      for (int k = 0; k < 32; k++) begin
        for (int p = 0; p < 6; p++) apply(req_of(2'(o)), 2'(o), pats[p], k);
        for (int r = 0; r < 6; r++) apply(req_of(2'(o)), 2'(o), $urandom, k);
      end

    // R5: zero amount is identity for every op
    for (int o = 0; o < 4; o++) begin
      @(negedge clk);
      op = 2'(o); data = 32'hC3A5_1E0F; amount = 5'd0;
      #1;
      check("R5", result, 32'hC3A5_1E0F);
    end

    // R6: largest amount
    @(negedge clk); op = 2'b00; data = 32'h8000_0000; amount = 5'd31; #1;
    check("R6", result, 32'h0000_0001);
    @(negedge clk); op = 2'b10; data = 32'h0000_0001; amount = 5'd31; #1;
    check("R6", result, 32'h8000_0000);
    @(negedge clk); op = 2'b01; data = 32'h8000_0000; amount = 5'd31; #1;
    check("R6", result, 32'hFFFF_FFFF);
    @(negedge clk); op = 2'b11; data = 32'h0000_0001; amount = 5'd31; #1;
    check("R6", result, 32'h0000_0002);

    // R7: output follows inputs within one clock phase
    @(negedge clk);
    op = 2'b11; data = 32'h0000_00F0; amount = 5'd4; #1;
    check("R7", result, 32'h0000_000F);
    op = 2'b10; amount = 5'd8; #1;
    check("R7", result, 32'h0000_F000);
    data = 32'h1234_5678; op = 2'b01; amount = 5'd16; #1;
    check("R7", result, 32'h0000_1234);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule